// File: doc/BRIEF.md
# Cascadable LED Sink Shift-Latch Driver

This block drives a row of common-anode LEDs through open-drain sink pins. Serial data enters a chain of shift stages on each low-to-high transition of a shift clock input. A separate latch clock input copies the whole chain into an output latch in one step. Each latched bit then either sinks current, which lights its LED, or leaves its pin floating. A high input bit is stored inverted on entry, so a high bit shifted in ends up as a lit LED once latched.

The last shift stage appears on a cascade output, so several drivers can be chained into a longer display. An asynchronous active-low reset turns every LED off. A float request releases all LED pins. Shifting, latching and the cascade output carry on while the pins are released.

The shift and latch clock inputs are treated as level inputs. They are sampled by the system clock `clk`, and their rising transitions are detected there. Each open-drain pin is modelled as a pad value that is always 0 plus a per-bit drive enable.

Top module: `ledsink_driver`

## Requirements
- R1: While `rstN` is low, every `sinkEn` bit is 0 and `cascadeOut` is 0. This holds at once when reset asserts, with no `clk` edge needed.
- R2: After reset is released, every shift stage and every latch bit holds the off level (1). `cascadeOut` then reads 1, and latching without any shift keeps every `sinkEn` bit at 0.
- R3: Each low-to-high transition of `shiftClkIn` causes exactly one shift. Stage 0 takes the inverse of `serIn`, and stage i takes the old value of stage i-1. Holding `shiftClkIn` high for several cycles still gives only one shift.
- R4: `cascadeOut` carries the level of the last stage (stage WIDTH-1). A bit shifted in appears there, inverted, after WIDTH shifts.
- R5: Each low-to-high transition of `latchClkIn` copies all stages into the latch. `sinkEn[i]` is 1 exactly when latch bit i is 0, provided `floatReq` is low and reset is inactive.
- R6: Shifting without a latch transition leaves `sinkEn` unchanged.
- R7: While `floatReq` is high, every `sinkEn` bit is 0 with no clock delay. Shifting and latching still proceed, and `cascadeOut` is unaffected.
- R8: When the shift and latch transitions are seen in the same `clk` cycle, the latch takes the contents as they were before that shift.
- R9: `sinkVal` is 0 on every bit at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the shift and latch clock inputs |
| rstN | input | 1 | Asynchronous active-low reset; turns all LEDs off |
| shiftClkIn | input | 1 | Shift clock level; a rising transition shifts once |
| latchClkIn | input | 1 | Latch clock level; a rising transition latches the stages |
| serIn | input | 1 | Serial data; a 1 becomes a lit LED once latched |
| floatReq | input | 1 | When high, releases every LED pin |
| sinkEn | output | WIDTH | Per-pin drive enable; 1 sinks current and lights the LED |
| sinkVal | output | WIDTH | Per-pin pad value, constant 0 |
| cascadeOut | output | 1 | Level of the last shift stage, for chaining |

## Verification
A shift or latch takes effect at the first rising edge of `clk` that sees its clock input high. The bench drives inputs on the falling edge and samples the ports one falling edge after the acting rising edge. The float request and reset act on the outputs combinationally, so the bench samples them 1 ns after it changes the input. Every expected value comes from an inverting reference model. The model is updated only once the acting rising edge has passed, so each queued expectation matches the cycle the design is due to produce it.

// File: rtl/ledsink_pkg.sv
package ledsink_pkg;
  typedef struct packed {
    logic doShift;
    logic doLatch;
  } strobes_t;
endpackage

// File: rtl/ledsink_ctrl.sv
module ledsink_ctrl
  import ledsink_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     shiftClkIn,
  input  logic     latchClkIn,
  output strobes_t strobes
);
  logic shiftPrev, latchPrev;

  // Previous levels reset high, so a clock held high through reset gives no edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftPrev <= 1'b1;
      latchPrev <= 1'b1;
    end else begin
      shiftPrev <= shiftClkIn;
      latchPrev <= latchClkIn;
    end
  end

  always_comb begin
    strobes.doShift = shiftClkIn & ~shiftPrev;
    strobes.doLatch = latchClkIn & ~latchPrev;
  end

  // R3: one rising transition gives a single shift strobe
  a_r3_single_shift: assert property (@(posedge clk) disable iff (!rstN)
    strobes.doShift |=> !strobes.doShift);

  // R5: one rising transition gives a single latch strobe
  a_r5_single_latch: assert property (@(posedge clk) disable iff (!rstN)
    strobes.doLatch |=> !strobes.doLatch);
endmodule

// File: rtl/ledsink_path.sv
module ledsink_path
  import ledsink_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobes_t         strobes,
  input  logic             serIn,
  input  logic             floatReq,
  output logic [WIDTH-1:0] sinkEn,
  output logic             cascadeOut
);
  localparam int LAST = WIDTH - 1;

  logic [WIDTH-1:0] stageQ;
  logic [WIDTH-1:0] latchQ;

  // Shift chain: data enters inverted at stage 0
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                stageQ <= '1;
    else if (strobes.doShift) stageQ <= {stageQ[LAST-1:0], ~serIn};
  end

  // Latch takes the pre-edge chain contents (nonblocking read)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                latchQ <= '1;
    else if (strobes.doLatch) latchQ <= stageQ;
  end

  assign cascadeOut = rstN & stageQ[LAST];

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    assign sinkEn[i] = rstN & ~floatReq & ~latchQ[i];
  end

  // R3: entry stage holds the inverse of the sampled serial input
  a_r3_entry_inverted: assert property (@(posedge clk) disable iff (!rstN)
    strobes.doShift |=> stageQ[0] == !$past(serIn));

  // R3: every other stage takes its predecessor
  a_r3_stage_move: assert property (@(posedge clk) disable iff (!rstN)
    strobes.doShift |=> stageQ[LAST:1] == $past(stageQ[LAST-1:0]));

  // R3: no shift strobe, no change in the chain
  a_r3_chain_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.doShift |=> $stable(stageQ));

  // R5/R8: latch captures the chain as it was before any same-cycle shift
  a_r8_latch_capture: assert property (@(posedge clk) disable iff (!rstN)
    strobes.doLatch |=> latchQ == $past(stageQ));

  // R6: latch is untouched without a latch strobe
  a_r6_latch_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.doLatch |=> $stable(latchQ));
endmodule

// File: rtl/ledsink_driver.sv
module ledsink_driver
  import ledsink_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             shiftClkIn,
  input  logic             latchClkIn,
  input  logic             serIn,
  input  logic             floatReq,
  output logic [WIDTH-1:0] sinkEn,
  output logic [WIDTH-1:0] sinkVal,
  output logic             cascadeOut
);
  strobes_t strobes;

  ledsink_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .shiftClkIn (shiftClkIn),
    .latchClkIn (latchClkIn),
    .strobes    (strobes)
  );

  ledsink_path #(.WIDTH(WIDTH)) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .serIn      (serIn),
    .floatReq   (floatReq),
    .sinkEn     (sinkEn),
    .cascadeOut (cascadeOut)
  );

  // R9: open-drain pads only ever pull low
  assign sinkVal = '0;
endmodule

// File: tb/ledsink_driver_tb.sv
`timescale 1ns/1ps
module ledsink_driver_tb;
  localparam int WIDTH = 16;

  typedef struct {
    string            req;
    logic [WIDTH-1:0] en;
    logic             casc;
  } expItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic shiftClkIn = 1'b0;
  logic latchClkIn = 1'b0;
  logic serIn = 1'b0;
  logic floatReq = 1'b0;
  logic [WIDTH-1:0] sinkEn, sinkVal;
  logic cascadeOut;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  logic [WIDTH-1:0] refShift = '1;
  logic [WIDTH-1:0] refLatch = '1;
  expItem_t expQ[$];

  always #10 clk = ~clk;

  ledsink_driver #(.WIDTH(WIDTH)) u_dut (
    .clk(clk), .rstN(rstN), .shiftClkIn(shiftClkIn), .latchClkIn(latchClkIn),
    .serIn(serIn), .floatReq(floatReq), .sinkEn(sinkEn), .sinkVal(sinkVal),
    .cascadeOut(cascadeOut)
  );

  // Monitor: pops expectations and compares against the ports
  initial begin
    forever begin
      expItem_t it;
      wait (expQ.size() != 0);
      it = expQ.pop_front();
      checks++;
      if (sinkEn !== it.en) begin
        fails++;
        $display("FAIL %s sinkEn actual=%h expected=%h", it.req, sinkEn, it.en);
      end
      checks++;
      if (cascadeOut !== it.casc) begin
        fails++;
        $display("FAIL %s cascadeOut actual=%b expected=%b", it.req, cascadeOut, it.casc);
      end
      checks++;
      if (sinkVal !== '0) begin
        fails++;
        $display("FAIL R9 sinkVal actual=%h expected=0", sinkVal);
      end
    end
  end

  // Driver side: push the model's expectation and let the monitor compare
  task automatic expectNow(input string req);
    expItem_t it;
    it.req  = req;
    it.en   = (rstN && !floatReq) ? ~refLatch : '0;
    it.casc = rstN ? refShift[WIDTH-1] : 1'b0;
    expQ.push_back(it);
    #1;
  endtask

  task automatic shiftBit(input logic b);
    @(negedge clk); serIn = b; shiftClkIn = 1'b1;
    @(negedge clk); shiftClkIn = 1'b0;
    refShift = {refShift[WIDTH-2:0], ~b};
  endtask

  task automatic latchPulse();
    @(negedge clk); latchClkIn = 1'b1;
    @(negedge clk); latchClkIn = 1'b0;
    refLatch = refShift;
  endtask

  task automatic shiftWord(input logic [WIDTH-1:0] w);
    for (int i = WIDTH - 1; i >= 0; i--) shiftBit(w[i]);
  endtask

  initial begin
    #5 expectNow("R1");                       // reset held from time zero
    repeat (3) @(negedge clk);
    expectNow("R1");
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    expectNow("R2");                          // all off, cascade reads 1
    latchPulse();
    expectNow("R2");                          // latching idle chain stays dark

    // Pattern A: shift without latch first
    shiftWord(16'hA5C3);
    expectNow("R6");                          // outputs still dark
    latchPulse();
    expectNow("R5");                          // lit where a 1 was shifted in

    // Pattern B under float request
    floatReq = 1'b1;
    #1 expectNow("R7");                       // pins released at once
    shiftWord(16'h0F01);
    expectNow("R7");
    latchPulse();
    expectNow("R7");
    floatReq = 1'b0;
    #1 expectNow("R7");                       // latched B appears when re-enabled

    // Held shift clock gives a single shift
    @(negedge clk); serIn = 1'b1; shiftClkIn = 1'b1;
    repeat (4) @(negedge clk);
    shiftClkIn = 1'b0;
    refShift = {refShift[WIDTH-2:0], 1'b0};
    latchPulse();
    expectNow("R3");

    // Cascade over 32 shifts: alternating-run pattern
    for (int k = 0; k < 32; k++) begin
      shiftBit(((k / 3) % 2) == 0);
      expectNow("R4");
    end

    // Simultaneous shift and latch edges
    shiftWord(16'h1234);
    @(negedge clk); serIn = 1'b1; shiftClkIn = 1'b1; latchClkIn = 1'b1;
    @(negedge clk); shiftClkIn = 1'b0; latchClkIn = 1'b0;
    refLatch = refShift;
    refShift = {refShift[WIDTH-2:0], 1'b0};
    expectNow("R8");
    latchPulse();
    expectNow("R8");

    // Asynchronous reset between clock edges
    @(negedge clk); #3 rstN = 1'b0;
    refShift = '1; refLatch = '1;
    #1 expectNow("R1");
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    expectNow("R2");
    shiftWord(16'hFFFF);
    latchPulse();
    expectNow("R5");

    wait (expQ.size() == 0);
    #1;
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule